// File: doc/BRIEF.md
# Banked Interrupt Controller

This block collects up to 96 interrupt request lines, arranged as three banks of 32, and condenses them into two processor request pins: a normal request (`irq_o`) and a fast request (`fiq_o`). Each source carries three configuration bits: an enable bit, a mask bit and a route-select bit. The enable bit decides whether an asserted source is latched as pending at all. The route-select bit decides whether that pending state goes to the normal or to the fast pending bank. The mask bit decides whether a pending source may drive its output pin.

Software reaches every register through a plain 32-bit word bus: address, write strobe, write data and a combinational read port. Pending bits stay set until software writes a 1 to them. A read-only vector word gives the number of the lowest active normal source, so a handler can be dispatched without scanning the banks. Source 0 is wired to an external non-maskable line. Its pending bit therefore holds its state until software clears it explicitly. Sources 80 to 95 are not implemented.

Top module: `banked_intc`

## Requirements
- R1: Source n is handled at bank n/32, bit n%32. Each register group takes one word per bank, at byte offsets base + 4*bank. The bases are: normal pending 0x10, fast pending 0x20, route select 0x30, enable 0x40, mask 0x50. Only word-aligned addresses are decoded.
- R2: A source that is high at a clock edge while its enable bit is 1 sets, at that edge, its bit in the normal pending bank if its select bit is 0, or its bit in the fast pending bank if its select bit is 1. A source whose enable bit is 0 leaves both pending banks unchanged.
- R3: A pending bit stays set after its source goes low.
- R4: Writing a pending word clears every bit written as 1 and leaves every bit written as 0 unchanged. The clear takes priority in the write cycle. If the source is still asserted, the bit is set again at the following edge.
- R5: `irq_o` is high exactly when some normal-pending bit has enable 1, mask 0 and select 0. A set mask bit blocks the output but does not stop capture.
- R6: `fiq_o` is high exactly when some fast-pending bit has enable 1, mask 0 and select 1.
- R7: The word at offset 0x00 reads as (number of the lowest-numbered source counted by R5) << 2, or as 0 when there is none. Writes to it have no effect.
- R8: After reset all select, enable, mask and pending bits and all control words read 0, and both output pins are low.
- R9: Sources 80 to 95 never become pending. Their select, enable and mask bits read 0 even after ones are written to them.
- R10: Source 0 (the external non-maskable line) keeps its normal-pending bit (bit 0 at 0x10) after a single-cycle pulse, until software writes 1 to that bit.
- R11: Offset 0x04 holds a 32-bit read/write word. Offset 0x08 holds a 1-bit protection flag in bit 0, and its other bits read 0. Offset 0x0c holds a 2-bit source-type field in bits 1:0. All three read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 96 | Interrupt source levels, bit n is source n |
| bus_addr | input | 8 | Byte address of the register word |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest case to reach is the write-1-to-clear on a pending bit whose source is still held high. The clear must win in the write cycle, and the bit must come back one edge later. The stimulus holds a source asserted across a pending-word write, reads the word in the cycle right after the write, and reads it again one cycle later. The same sequence also walks the priority order of the vector word. Lower-numbered sources are cleared or masked one by one, so that the winner moves across a bank boundary and finally to none.

// File: rtl/intc_pkg.sv
package intc_pkg;

   localparam int BUS_W = 32;

   // register groups, selected by address bits 7:4
   localparam logic [3:0] GRP_CTRL  = 4'h0;
   localparam logic [3:0] GRP_IPEND = 4'h1;
   localparam logic [3:0] GRP_FPEND = 4'h2;
   localparam logic [3:0] GRP_SEL   = 4'h3;
   localparam logic [3:0] GRP_EN    = 4'h4;
   localparam logic [3:0] GRP_MASK  = 4'h5;

   // words inside the control group, selected by address bits 3:2
   typedef enum logic [1:0] {
      CTL_VECTOR = 2'd0,
      CTL_BASE   = 2'd1,
      CTL_PROT   = 2'd2,
      CTL_SRCTYP = 2'd3
   } ctl_word_e;

   // bits of one bank that map to implemented sources
   function automatic logic [BUS_W-1:0] bank_live(int bank, int width, int live);
      logic [BUS_W-1:0] m;
      m = '0;
      for (int i = 0; i < width; i++) begin
         if (bank * width + i < live) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/intc_lowest.sv
module intc_lowest #(
   parameter int W     = 96,
   parameter int IDX_W = $clog2(W)
) (
   input  logic [W-1:0]     vec_i,
   output logic             found_o,
   output logic [IDX_W-1:0] idx_o
);

   if (W < 2) begin : g_bad_w
      $error("intc_lowest: W must be at least 2");
   end

   // scan from the top down so the last hit is the lowest index
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec_i[i]) begin
            found_o = 1'b1;
            idx_o   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
   parameter int               BANK_W = 32,
   parameter logic [BANK_W-1:0] LIVE  = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] src_i,
   input  logic              we_sel,
   input  logic              we_en,
   input  logic              we_mask,
   input  logic              we_ipend,
   input  logic              we_fpend,
   input  logic [BANK_W-1:0] wdata,
   output logic [BANK_W-1:0] sel_q,
   output logic [BANK_W-1:0] en_q,
   output logic [BANK_W-1:0] mask_q,
   output logic [BANK_W-1:0] ipend_q,
   output logic [BANK_W-1:0] fpend_q,
   output logic [BANK_W-1:0] irq_act_o,
   output logic              irq_req_o,
   output logic              fiq_req_o
);

   logic [BANK_W-1:0] capture;
   logic [BANK_W-1:0] iset, fset, iclr, fclr;
   logic [BANK_W-1:0] grant;

   assign capture = src_i & en_q & LIVE;
   assign iset    = capture & ~sel_q;
   assign fset    = capture & sel_q;
   assign iclr    = we_ipend ? wdata : '0;
   assign fclr    = we_fpend ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= '0;
         en_q    <= '0;
         mask_q  <= '0;
         ipend_q <= '0;
         fpend_q <= '0;
      end else begin
         if (we_sel)  sel_q  <= wdata & LIVE;
         if (we_en)   en_q   <= wdata & LIVE;
         if (we_mask) mask_q <= wdata & LIVE;
         ipend_q <= (ipend_q | iset) & ~iclr;
         fpend_q <= (fpend_q | fset) & ~fclr;
      end
   end

   assign grant     = en_q & ~mask_q;
   assign irq_act_o = ipend_q & grant & ~sel_q;
   assign irq_req_o = |irq_act_o;
   assign fiq_req_o = |(fpend_q & grant & sel_q);

   assert_w1c_ipend_R4: assert property (@(posedge clk) disable iff (!rst_n)
      we_ipend |=> ((ipend_q & $past(wdata)) == '0));

   assert_w1c_fpend_R4: assert property (@(posedge clk) disable iff (!rst_n)
      we_fpend |=> ((fpend_q & $past(wdata)) == '0));

   assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !we_ipend |=> ((($past(src_i) & $past(en_q) & ~$past(sel_q) & LIVE) & ~ipend_q) == '0));

   assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_ipend && !we_fpend) |=>
         ((($past(ipend_q) & ~ipend_q) | ($past(fpend_q) & ~fpend_q)) == '0));

   assert_dead_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((ipend_q | fpend_q | sel_q | en_q | mask_q) & ~LIVE) == '0);

endmodule

// File: rtl/banked_intc.sv
module banked_intc
   import intc_pkg::*;
#(
   parameter int NUM_BANKS = 3,
   parameter int NUM_LIVE  = 80,
   parameter int ADDR_W    = 8,
   parameter int SRCTYP_W  = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_BANKS*BUS_W-1:0] src_i,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic                       bus_we,
   input  logic [BUS_W-1:0]           bus_wdata,
   output logic [BUS_W-1:0]           bus_rdata,
   output logic                       irq_o,
   output logic                       fiq_o
);

   localparam int NSRC  = NUM_BANKS * BUS_W;
   localparam int IDX_W = $clog2(NSRC);

   if (NUM_BANKS < 1 || NUM_BANKS > 4) begin : g_bad_banks
      $error("banked_intc: NUM_BANKS must be 1..4");
   end
   if (NUM_LIVE < 1 || NUM_LIVE > NSRC) begin : g_bad_live
      $error("banked_intc: NUM_LIVE out of range");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("banked_intc: ADDR_W must be at least 8");
   end
   if (SRCTYP_W < 1 || SRCTYP_W > BUS_W) begin : g_bad_typ
      $error("banked_intc: SRCTYP_W out of range");
   end

   // ---------------- address decode ----------------
   logic       hit;
   logic [3:0] grp;
   logic [1:0] widx;

   assign grp  = bus_addr[7:4];
   assign widx = bus_addr[3:2];

   if (ADDR_W > 8) begin : g_hit_wide
      assign hit = (bus_addr[ADDR_W-1:8] == '0) && (bus_addr[1:0] == 2'b00);
   end else begin : g_hit_narrow
      assign hit = (bus_addr[1:0] == 2'b00);
   end

   // ---------------- banks ----------------
   logic [BUS_W-1:0]     sel_b   [NUM_BANKS];
   logic [BUS_W-1:0]     en_b    [NUM_BANKS];
   logic [BUS_W-1:0]     mask_b  [NUM_BANKS];
   logic [BUS_W-1:0]     ipend_b [NUM_BANKS];
   logic [BUS_W-1:0]     fpend_b [NUM_BANKS];
   logic [NUM_BANKS-1:0] irq_req_b;
   logic [NUM_BANKS-1:0] fiq_req_b;
   logic [NSRC-1:0]      act_all;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam logic [BUS_W-1:0] LIVE_B = bank_live(b, BUS_W, NUM_LIVE);
      logic we_b;
      assign we_b = bus_we && hit && (widx == 2'(b));

      intc_bank #(
         .BANK_W (BUS_W),
         .LIVE   (LIVE_B)
      ) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .src_i     (src_i[b*BUS_W +: BUS_W]),
         .we_sel    (we_b && (grp == GRP_SEL)),
         .we_en     (we_b && (grp == GRP_EN)),
         .we_mask   (we_b && (grp == GRP_MASK)),
         .we_ipend  (we_b && (grp == GRP_IPEND)),
         .we_fpend  (we_b && (grp == GRP_FPEND)),
         .wdata     (bus_wdata),
         .sel_q     (sel_b[b]),
         .en_q      (en_b[b]),
         .mask_q    (mask_b[b]),
         .ipend_q   (ipend_b[b]),
         .fpend_q   (fpend_b[b]),
         .irq_act_o (act_all[b*BUS_W +: BUS_W]),
         .irq_req_o (irq_req_b[b]),
         .fiq_req_o (fiq_req_b[b])
      );
   end

   assign irq_o = |irq_req_b;
   assign fiq_o = |fiq_req_b;

   // ---------------- vector ----------------
   logic             found;
   logic [IDX_W-1:0] win_idx;
   logic [BUS_W-1:0] vector_w;

   intc_lowest #(
      .W     (NSRC),
      .IDX_W (IDX_W)
   ) u_lowest (
      .vec_i   (act_all),
      .found_o (found),
      .idx_o   (win_idx)
   );

   assign vector_w = found ? BUS_W'({win_idx, 2'b00}) : '0;

   // ---------------- control words ----------------
   logic [BUS_W-1:0]    base_q;
   logic                prot_q;
   logic [SRCTYP_W-1:0] srctyp_q;
   logic                ctl_we;

   assign ctl_we = bus_we && hit && (grp == GRP_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '0;
         prot_q   <= 1'b0;
         srctyp_q <= '0;
      end else if (ctl_we) begin
         case (ctl_word_e'(widx))
            CTL_BASE:   base_q   <= bus_wdata;
            CTL_PROT:   prot_q   <= bus_wdata[0];
            CTL_SRCTYP: srctyp_q <= bus_wdata[SRCTYP_W-1:0];
            default:    ;
         endcase
      end
   end

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         if (grp == GRP_CTRL) begin
            case (ctl_word_e'(widx))
               CTL_VECTOR: bus_rdata = vector_w;
               CTL_BASE:   bus_rdata = base_q;
               CTL_PROT:   bus_rdata = BUS_W'(prot_q);
               CTL_SRCTYP: bus_rdata = BUS_W'(srctyp_q);
               default:    bus_rdata = '0;
            endcase
         end else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
               if (widx == 2'(b)) begin
                  case (grp)
                     GRP_IPEND: bus_rdata = ipend_b[b];
                     GRP_FPEND: bus_rdata = fpend_b[b];
                     GRP_SEL:   bus_rdata = sel_b[b];
                     GRP_EN:    bus_rdata = en_b[b];
                     GRP_MASK:  bus_rdata = mask_b[b];
                     default:   bus_rdata = '0;
                  endcase
               end
            end
         end
      end
   end

   // ---------------- assertions ----------------
   assert_irq_matches_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == found);

   assert_vec_winner_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> act_all[win_idx]);

   assert_vec_none_lower_R7: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> ((act_all & ((NSRC'(1) << win_idx) - NSRC'(1))) == '0));

   assert_prot_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && widx == 2'(CTL_PROT)) |=> (prot_q == $past(bus_wdata[0])));

endmodule

// File: tb/banked_intc_tb.sv
`timescale 1ns/1ps
module banked_intc_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [95:0] src = '0;
   logic [7:0]  addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq, fiq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct {
      int          kind;   // 0 read word, 1 irq pin, 2 fiq pin
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t exp_q[$];
   event  sample_ev;

   always #4 clk = ~clk;

   banked_intc u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src),
      .bus_addr  (addr),
      .bus_we    (we),
      .bus_wdata (wdata),
      .bus_rdata (rdata),
      .irq_o     (irq),
      .fiq_o     (fiq)
   );

   // monitor: pops expected items and compares with the design
   initial begin
      forever begin
         @(sample_ev);
         while (exp_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = exp_q.pop_front();
            act = (it.kind == 0) ? rdata : (it.kind == 1) ? {31'd0, irq} : {31'd0, fiq};
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic push(int kind, logic [31:0] e, string tag);
      item_t it;
      it.kind = kind; it.exp = e; it.tag = tag;
      exp_q.push_back(it);
      #1;
      -> sample_ev;
      #1;
   endtask

   task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
      addr = a;
      push(0, e, tag);
   endtask

   task automatic pin_irq(logic e, string tag);
      push(1, {31'd0, e}, tag);
   endtask

   task automatic pin_fiq(logic e, string tag);
      push(2, {31'd0, e}, tag);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog all-requirements actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);

      // R8 reset state
      rd(8'h00, 32'h0, "R8 vector after reset");
      rd(8'h10, 32'h0, "R8 ipend0 after reset");
      rd(8'h28, 32'h0, "R8 fpend2 after reset");
      rd(8'h30, 32'h0, "R8 select0 after reset");
      rd(8'h44, 32'h0, "R8 enable1 after reset");
      rd(8'h58, 32'h0, "R8 mask2 after reset");
      rd(8'h08, 32'h0, "R8 protection after reset");
      pin_irq(1'b0, "R8 irq after reset");
      pin_fiq(1'b0, "R8 fiq after reset");

      // R2 capture gated by enable
      wr(8'h40, 32'h0000_0020);
      src[5] = 1'b1; src[3] = 1'b1;
      step(1);
      rd(8'h10, 32'h0000_0020, "R2 enabled source captured, disabled not");
      rd(8'h20, 32'h0, "R2 select 0 leaves fast bank empty");
      pin_irq(1'b1, "R5 irq for enabled unmasked source");
      rd(8'h00, 32'd20, "R7 vector for source 5");

      // R3 sticky
      src[5] = 1'b0; src[3] = 1'b0;
      step(2);
      rd(8'h10, 32'h0000_0020, "R3 pending held after source drop");

      // R1 bank mapping
      wr(8'h44, 32'h0000_0102);
      src[40] = 1'b1;
      step(1);
      rd(8'h14, 32'h0000_0100, "R1 source 40 at bank1 bit8");
      rd(8'h00, 32'd20, "R7 lower source 5 still wins");
      wr(8'h10, 32'h0000_0020);
      rd(8'h10, 32'h0, "R4 write-one clears bit5");
      rd(8'h00, 32'd160, "R7 winner moves to source 40");
      src[33] = 1'b1;
      step(1);
      rd(8'h14, 32'h0000_0102, "R1 source 33 at bank1 bit1");
      rd(8'h00, 32'd132, "R7 source 33 beats 40");
      src[33] = 1'b0;

      // R4 zeros no effect, clear wins then re-set
      wr(8'h14, 32'h0);
      rd(8'h14, 32'h0000_0102, "R4 zero write leaves pending");
      wr(8'h14, 32'h0000_0102);
      rd(8'h14, 32'h0, "R4 clear wins in write cycle");
      step(1);
      rd(8'h14, 32'h0000_0100, "R4 held source re-sets next edge");

      // R5 mask blocks output, not capture
      wr(8'h54, 32'h0000_0100);
      pin_irq(1'b0, "R5 mask blocks irq");
      rd(8'h00, 32'h0, "R7 vector zero when nothing active");
      step(1);
      rd(8'h14, 32'h0000_0100, "R5 masked source still pending");

      // R6 fast route
      wr(8'h38, 32'h0000_0040);
      wr(8'h48, 32'h0000_0040);
      src[70] = 1'b1;
      step(1);
      rd(8'h28, 32'h0000_0040, "R6 source 70 in fast pending");
      rd(8'h18, 32'h0, "R6 source 70 not in normal pending");
      pin_fiq(1'b1, "R6 fiq asserted");
      pin_irq(1'b0, "R5 irq low with fast-only source");
      wr(8'h58, 32'h0000_0040);
      pin_fiq(1'b0, "R6 mask blocks fiq");

      // R9 dead sources
      wr(8'h48, 32'hFFFF_FFFF);
      rd(8'h48, 32'h0000_FFFF, "R9 enable upper bits read zero");
      wr(8'h38, 32'hFFFF_FFFF);
      rd(8'h38, 32'h0000_FFFF, "R9 select upper bits read zero");
      wr(8'h58, 32'hFFFF_FFFF);
      rd(8'h58, 32'h0000_FFFF, "R9 mask upper bits read zero");
      src[95:80] = '1;
      step(1);
      rd(8'h28, 32'h0000_0040, "R9 sources 80-95 never pending (fast)");
      rd(8'h18, 32'h0, "R9 sources 80-95 never pending (normal)");
      src[95:80] = '0;

      // R10 external line on source 0
      wr(8'h40, 32'h0000_0001);
      src[0] = 1'b1;
      step(1);
      src[0] = 1'b0;
      step(3);
      rd(8'h10, 32'h0000_0001, "R10 pulse on source 0 held");
      pin_irq(1'b1, "R10 irq from source 0");
      rd(8'h00, 32'h0, "R7 vector for source 0");
      wr(8'h10, 32'h0000_0001);
      rd(8'h10, 32'h0, "R10 explicit clear of source 0");
      pin_irq(1'b0, "R10 irq low after clear");

      // R11 control words
      wr(8'h04, 32'hDEAD_BEEF);
      rd(8'h04, 32'hDEAD_BEEF, "R11 base word read back");
      wr(8'h08, 32'hFFFF_FFFF);
      rd(8'h08, 32'h0000_0001, "R11 protection bit only");
      wr(8'h0C, 32'h0000_00FF);
      rd(8'h0C, 32'h0000_0003, "R11 source-type field");

      // R7 vector write ignored
      wr(8'h54, 32'h0);
      pin_irq(1'b1, "R5 unmask restores irq");
      wr(8'h00, 32'h0000_03FC);
      rd(8'h00, 32'd160, "R7 vector write ignored");
      pin_irq(1'b1, "R7 irq unchanged by vector write");

      step(2);
      done = 1;
      summary();
      $finish;
   end

endmodule